// File: doc/BRIEF.md
# Age-Priority Processor-Memory Crossbar Arbiter

This block decides, once per memory cycle, which processing elements are connected to which single-ported memory modules. Each element may present a request that names one module. A module can serve only one element in a cycle. When several elements want the same module, the element that has waited longest wins. Among elements that have waited equally long, the lowest index wins. All modules are released at the end of the cycle, and arbitration starts again from scratch in the next one.

An element that loses keeps its request inside the arbiter and retries the same module on every following cycle until it is served. While it waits, its own request inputs are ignored. Each element has a saturating wait counter, and that counter is the age used for priority. Grants are registered, so a request presented in cycle n shows up as a grant in cycle n+1. The per-module busy map is decoded combinationally from those registered grants. The element count and the module count are independent parameters.

Top module: `age_xbar`

## Requirements
- R1: While reset is asserted, every grant bit, every grantTarget field and every busy bit read zero, and no element holds a pending request.
- R2: A request presented in a cycle with no competitor for its module appears as grant high, with grantTarget equal to the requested module index, in the following cycle. Requests to different modules are all granted in parallel.
- R3: In any cycle, at most one asserted grant carries a given module index.
- R4: Among competitors for one module whose wait counts are equal, the lowest-indexed element is granted.
- R5: A competitor with a larger wait count is granted ahead of any competitor with a smaller wait count, whatever their indices.
- R6: A denied element keeps its module index and competes again in the next cycle without asserting reqValid. Its reqValid and reqTarget inputs are ignored until it has been granted.
- R7: An element's wait count clears to zero when it is granted. It rises by one for each cycle in which the element competes and is denied, and it stops at 2^WAIT_W-1.
- R8: busy bit j is 1 in exactly those cycles where some asserted grant has grantTarget equal to j. When grant is low, that element's grantTarget reads zero.
- R9: An element with no request and nothing pending receives no grant in the next cycle, and its wait count stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PE | Element i presents a new request this cycle |
| reqTarget | input | NUM_PE*TGT_W | Module index of element i, in field i |
| grant | output | NUM_PE | Element i is connected this cycle |
| grantTarget | output | NUM_PE*TGT_W | Module index element i is connected to, in field i (zero if not granted) |
| busy | output | NUM_MEM | Module j is connected this cycle |

## Verification
The hardest case to reach from the ports is a contest in which age and index disagree: an older, higher-indexed element competes against a fresh, lower-indexed one for the same module while a third element is still waiting. The stimulus first makes several elements collide on one module so that the losers build up age. It then brings in new low-index requests to that same module and changes the reqTarget inputs of the waiting elements, so that both priority by age and the ignoring of held inputs are exposed. A long stretch of dense random requests aimed at only two modules follows, and a scoreboard model predicts every cycle's grants.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Per-element strobes from the control half to the datapath half.
  typedef struct packed {
    logic take;  // element won its module this cycle
    logic hold;  // element competed and lost; keep its request
  } peCtl_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int TGT_W  = 3,
  parameter int WAIT_W = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_PE-1:0]                effValid,
  input  logic [NUM_PE-1:0][TGT_W-1:0]     effTgt,
  output peCtl_t [NUM_PE-1:0]              ctl,
  output logic [NUM_PE-1:0][WAIT_W-1:0]    waitCnt
);
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

  logic [NUM_PE-1:0] win;

  for (genvar gi = 0; gi < NUM_PE; gi++) begin : g_pe
    // blockedBy[j]: element j targets the same module and ranks above gi
    logic [NUM_PE-1:0] blockedBy;

    always_comb begin
      for (int j = 0; j < NUM_PE; j++) begin
        blockedBy[j] = 1'b0;
        if (j != gi) begin
          blockedBy[j] = effValid[j] && (effTgt[j] == effTgt[gi]) &&
                         ((waitCnt[j] > waitCnt[gi]) ||
                          ((waitCnt[j] == waitCnt[gi]) && (j < gi)));
        end
      end
    end

    assign win[gi]      = effValid[gi] && !(|blockedBy);
    assign ctl[gi].take = win[gi];
    assign ctl[gi].hold = effValid[gi] && !win[gi];

    // Age counter: cleared on a win or when idle, saturating on denial.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        waitCnt[gi] <= '0;
      end else if (!ctl[gi].hold) begin
        waitCnt[gi] <= '0;
      end else if (waitCnt[gi] != WAIT_MAX) begin
        waitCnt[gi] <= waitCnt[gi] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_dp.sv
module xbar_dp
  import xbar_pkg::*;
#(
  parameter int NUM_PE  = 4,
  parameter int NUM_MEM = 8,
  parameter int TGT_W   = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PE-1:0]            reqValid,
  input  logic [NUM_PE-1:0][TGT_W-1:0] reqTgt,
  input  peCtl_t [NUM_PE-1:0]          ctl,
  output logic [NUM_PE-1:0]            effValid,
  output logic [NUM_PE-1:0][TGT_W-1:0] effTgt,
  output logic [NUM_PE-1:0]            grant,
  output logic [NUM_PE-1:0][TGT_W-1:0] grantTgt,
  output logic [NUM_MEM-1:0]           busy
);
  logic [NUM_PE-1:0]            pending;
  logic [NUM_PE-1:0][TGT_W-1:0] heldTgt;

  // A pending element competes with its held module; fresh inputs are masked.
  assign effValid = reqValid | pending;

  always_comb begin
    for (int i = 0; i < NUM_PE; i++) begin
      effTgt[i] = pending[i] ? heldTgt[i] : reqTgt[i];
    end
  end

  for (genvar gi = 0; gi < NUM_PE; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pending[gi]  <= 1'b0;
        heldTgt[gi]  <= '0;
        grant[gi]    <= 1'b0;
        grantTgt[gi] <= '0;
      end else begin
        pending[gi]  <= ctl[gi].hold;
        if (ctl[gi].hold) begin
          heldTgt[gi] <= effTgt[gi];
        end
        grant[gi]    <= ctl[gi].take;
        grantTgt[gi] <= ctl[gi].take ? effTgt[gi] : '0;
      end
    end
  end

  // Busy map decoded from the registered grants of the current cycle.
  always_comb begin
    busy = '0;
    for (int j = 0; j < NUM_MEM; j++) begin
      for (int i = 0; i < NUM_PE; i++) begin
        if (grant[i] && (grantTgt[i] == TGT_W'(j))) begin
          busy[j] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/age_xbar.sv
module age_xbar
  import xbar_pkg::*;
#(
  parameter int NUM_PE  = 4,
  parameter int NUM_MEM = 8,
  parameter int WAIT_W  = 2,
  localparam int TGT_W  = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PE-1:0]       reqValid,
  input  logic [NUM_PE*TGT_W-1:0] reqTarget,
  output logic [NUM_PE-1:0]       grant,
  output logic [NUM_PE*TGT_W-1:0] grantTarget,
  output logic [NUM_MEM-1:0]      busy
);
  logic [NUM_PE-1:0]             effValid;
  logic [NUM_PE-1:0][TGT_W-1:0]  effTgt;
  logic [NUM_PE-1:0][TGT_W-1:0]  reqTgtArr;
  logic [NUM_PE-1:0][TGT_W-1:0]  grantTgtArr;
  logic [NUM_PE-1:0][WAIT_W-1:0] waitCnt;
  peCtl_t [NUM_PE-1:0]           ctl;

  assign reqTgtArr   = reqTarget;
  assign grantTarget = grantTgtArr;

  xbar_ctrl #(
    .NUM_PE(NUM_PE), .TGT_W(TGT_W), .WAIT_W(WAIT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .effValid(effValid), .effTgt(effTgt),
    .ctl(ctl), .waitCnt(waitCnt)
  );

  xbar_dp #(
    .NUM_PE(NUM_PE), .NUM_MEM(NUM_MEM), .TGT_W(TGT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqTgt(reqTgtArr), .ctl(ctl),
    .effValid(effValid), .effTgt(effTgt),
    .grant(grant), .grantTgt(grantTgtArr), .busy(busy)
  );
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk
  import xbar_pkg::*;
#(
  parameter int NUM_PE  = 4,
  parameter int NUM_MEM = 8,
  parameter int TGT_W   = 3,
  parameter int WAIT_W  = 2
) (
  input logic                             clk,
  input logic                             rstN,
  input logic [NUM_PE-1:0]                effValid,
  input logic [NUM_PE-1:0][TGT_W-1:0]     effTgt,
  input peCtl_t [NUM_PE-1:0]              ctl,
  input logic [NUM_PE-1:0][WAIT_W-1:0]    waitCnt,
  input logic [NUM_PE-1:0]                grant,
  input logic [NUM_PE*TGT_W-1:0]          grantTarget,
  input logic [NUM_MEM-1:0]               busy
);
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

  logic [NUM_PE-1:0][TGT_W-1:0] gT;
  assign gT = grantTarget;

  for (genvar gm = 0; gm < NUM_MEM; gm++) begin : g_mod
    logic [NUM_PE-1:0] users;
    always_comb begin
      for (int i = 0; i < NUM_PE; i++) begin
        users[i] = grant[i] && (gT[i] == TGT_W'(gm));
      end
    end
    p_one_user_r3: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(users));
  end

  for (genvar gi = 0; gi < NUM_PE; gi++) begin : g_pe
    p_grant_next_r2: assert property (@(posedge clk) disable iff (!rstN)
      ctl[gi].take |=> grant[gi] && (gT[gi] == $past(effTgt[gi])));

    p_hold_target_r6: assert property (@(posedge clk) disable iff (!rstN)
      ctl[gi].hold |=> effValid[gi] && (effTgt[gi] == $past(effTgt[gi])));

    p_wait_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      ctl[gi].take |=> (waitCnt[gi] == '0));

    p_wait_inc_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ctl[gi].hold && (waitCnt[gi] != WAIT_MAX)) |=>
        (waitCnt[gi] == $past(waitCnt[gi]) + 1'b1));

    p_wait_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ctl[gi].hold && (waitCnt[gi] == WAIT_MAX)) |=> (waitCnt[gi] == WAIT_MAX));

    p_busy_set_r8: assert property (@(posedge clk) disable iff (!rstN)
      grant[gi] |-> busy[gT[gi]]);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
      !effValid[gi] |=> !grant[gi] && (waitCnt[gi] == '0));

    for (genvar gj = 0; gj < NUM_PE; gj++) begin : g_rival
      if (gj != gi) begin : g_pair
        p_age_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
          !(ctl[gi].take && effValid[gj] && (effTgt[gj] == effTgt[gi]) &&
            (waitCnt[gj] > waitCnt[gi])));
      end
      if (gj < gi) begin : g_tie
        p_low_index_r4: assert property (@(posedge clk) disable iff (!rstN)
          !(ctl[gi].take && effValid[gj] && (effTgt[gj] == effTgt[gi]) &&
            (waitCnt[gj] == waitCnt[gi])));
      end
    end
  end

  p_busy_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(busy) <= $countones(grant));
endmodule

bind age_xbar xbar_chk #(
  .NUM_PE(NUM_PE), .NUM_MEM(NUM_MEM), .TGT_W(TGT_W), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .effValid(effValid), .effTgt(effTgt),
  .ctl(ctl), .waitCnt(waitCnt), .grant(grant), .grantTarget(grantTarget),
  .busy(busy)
);

// File: tb/tb_age_xbar.sv
module tb_age_xbar;
  localparam int NP   = 4;
  localparam int NM   = 8;
  localparam int TW   = 3;
  localparam int WW   = 2;
  localparam int WMAX = (1 << WW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]    reqValid = '0;
  logic [NP*TW-1:0] reqTarget = '0;
  logic [NP-1:0]    grant;
  logic [NP*TW-1:0] grantTarget;
  logic [NM-1:0]    busy;

  age_xbar #(.NUM_PE(NP), .NUM_MEM(NM), .WAIT_W(WW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTarget(reqTarget),
    .grant(grant), .grantTarget(grantTarget), .busy(busy)
  );

  typedef struct {
    logic [NP-1:0]    g;
    logic [NP*TW-1:0] t;
    logic [NM-1:0]    b;
    string            tag;
  } exp_t;

  exp_t sbq[$];
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  // reference model state
  bit mPend[NP];
  int mTgt[NP];
  int mWait[NP];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of requests and push the predicted outcome.
  task automatic step(input logic [NP-1:0] v, input int t0, input int t1,
                      input int t2, input int t3, input string tag);
    int tg[NP];
    bit eV[NP];
    int eT[NP];
    bit w[NP];
    exp_t e;
    tg = '{t0, t1, t2, t3};
    @(negedge clk);
    reqValid = v;
    for (int i = 0; i < NP; i++) reqTarget[i*TW +: TW] = TW'(tg[i]);
    for (int i = 0; i < NP; i++) begin
      eV[i] = mPend[i] || v[i];
      eT[i] = mPend[i] ? mTgt[i] : tg[i];
    end
    for (int i = 0; i < NP; i++) begin
      w[i] = eV[i];
      for (int j = 0; j < NP; j++) begin
        if (j != i && eV[j] && eT[j] == eT[i] &&
            (mWait[j] > mWait[i] || (mWait[j] == mWait[i] && j < i)))
          w[i] = 1'b0;
      end
    end
    e.g = '0; e.t = '0; e.b = '0; e.tag = tag;
    for (int i = 0; i < NP; i++) begin
      if (w[i]) begin
        e.g[i] = 1'b1;
        e.t[i*TW +: TW] = TW'(eT[i]);
        e.b[eT[i]] = 1'b1;
      end
      mPend[i] = eV[i] && !w[i];
      mTgt[i]  = eT[i];
      if (w[i] || !eV[i]) mWait[i] = 0;
      else if (mWait[i] < WMAX) mWait[i] = mWait[i] + 1;
    end
    sbq.push_back(e);
  endtask

  // Monitor: compare one registered result per cycle, away from the edge.
  initial begin
    exp_t e;
    int cnt;
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        check(grant == e.g, e.tag, "grant", grant, e.g);
        check(grantTarget == e.t, e.tag, "grantTarget", grantTarget, e.t);
        check(busy == e.b, {e.tag, " R8"}, "busy", busy, e.b);
        for (int j = 0; j < NM; j++) begin
          cnt = 0;
          for (int i = 0; i < NP; i++)
            if (grant[i] && grantTarget[i*TW +: TW] == TW'(j)) cnt++;
          check(cnt <= 1, "R3", $sformatf("grants on module %0d", j), cnt, 1);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      mPend[i] = 1'b0; mTgt[i] = 0; mWait[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(grant == '0, "R1", "reset grant", grant, 0);
    check(grantTarget == '0, "R1", "reset grantTarget", grantTarget, 0);
    check(busy == '0, "R1", "reset busy", busy, 0);
    rstN = 1'b1;

    // R2: lone request, then four parallel distinct modules
    step(4'b0100, 0, 0, 5, 0, "R2");
    step(4'b1111, 0, 1, 2, 3, "R2");
    step(4'b0000, 0, 0, 0, 0, "R9");

    // R4: four-way collision on module 3, equal ages
    step(4'b1111, 3, 3, 3, 3, "R4");
    // P0 asks for 7; waiting P1..P3 hold 3 despite new inputs (R6)
    step(4'b0001, 7, 6, 6, 6, "R4 R6");
    step(4'b1110, 0, 1, 1, 1, "R6");
    step(4'b0000, 0, 0, 0, 0, "R6");
    step(4'b0000, 0, 0, 0, 0, "R9");

    // R5: older P3 beats fresh lower-index P0
    step(4'b1010, 0, 4, 0, 4, "R4");
    step(4'b0001, 4, 0, 0, 0, "R5");
    step(4'b0000, 0, 0, 0, 0, "R9");

    // R7: sustained four-way contention rotates service by age
    for (int k = 0; k < 8; k++) step(4'b1111, 6, 6, 6, 6, "R7 R5");
    step(4'b0000, 0, 0, 0, 0, "R7");
    step(4'b0000, 0, 0, 0, 0, "R9");

    // dense random traffic on two modules
    for (int k = 0; k < 400; k++)
      step(NP'($urandom_range(15)), $urandom_range(1), $urandom_range(1),
           $urandom_range(1), $urandom_range(1), "R3 R5 R6 R7");
    for (int k = 0; k < 4; k++) step(4'b0000, 0, 0, 0, 0, "R9");

    while (sbq.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule